// File: doc/BRIEF.md
# Switchable-Order Single-Bit Noise-Shaping Modulator

This block turns a stream of oversampled signed samples into a one-bit stream whose local average follows the input. Quantization noise is pushed away from low frequencies. It has one feedback loop. Every enabled cycle takes one sample and yields exactly one bit.

The block holds five cascaded integrators. Each stage receives a weighted copy of the input and a weighted copy of the fed-back bit. All stage weights are constants fixed when the block is elaborated. A run-time mode input selects the loop order:

- Five stages are used for 18-, 20- and 24-bit material.
- Three stages are used for 16-bit material. In this mode the two upper stages are parked at zero and the quantizer looks at the third integrator.

Every integrator is a 40-bit register. An integrator clamps at the signed 40-bit limits rather than wrapping. This keeps an overloaded loop from flipping sign.

Top module: `nshape_mod`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `bitOut` = 0, `bitVld` = 0 and all five integrators at zero.
- R2: `bitVld` is 1 in the cycle after an edge where `sampleVld` was 1, and 0 after an edge where `sampleVld` was 0. One bit is produced per accepted sample.
- R3: On each accepted sample, `bitOut` becomes 1 if the selected integrator's updated value is zero or positive, and 0 if it is negative. The selected integrator is the fifth when `fifthOrder` = 1 and the third when `fifthOrder` = 0.
- R4: The bit fed back is +FS for a 1 and −FS for a 0, with FS = 2^(DATA_W−1) integrator LSBs. After reset the first feedback is −FS. A zero input with positive feedback weights therefore gives a first bit of 1.
- R5: With `fifthOrder` = 1 and stage term t_k = B_k·x − A_k·fb, each update uses only the old states (i1..i5):
  - i1 ← i1+t1
  - i2 ← i2+t2+i1
  - i3 ← i3+t3+t2+i2+i1
  - i4 ← i4+t4+i3
  - i5 ← i5+t5+t4+i4+i3
- R6: With `fifthOrder` = 0, stages one to three update as in R5 and stages four and five are written to zero on each accepted sample.
- R7: After a switch from three to five stages, stages four and five start integrating from zero.
- R8: Each updated integrator value is clamped to the range −2^39 to 2^39−1 instead of wrapping.
- R9: A cycle with `sampleVld` = 0 changes neither `bitOut` nor any integrator.
- R10: Consider a weight set in which only the last active stage has A = B = 1 and every other weight is zero. Over 1024 samples of constant input x, the count of ones is within 3 of 1024·(1+x/FS)/2.
- R11: A reset asserted mid-stream restores the R1 state, and the next sample behaves like the first sample after power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at the oversampled rate |
| rst | input | 1 | Synchronous reset, active high |
| sampleVld | input | 1 | Accept `sampleIn` and advance the loop this cycle |
| sampleIn | input | DATA_W | Signed two's-complement oversampled input |
| fifthOrder | input | 1 | 1 = five-stage loop, 0 = three-stage loop |
| bitOut | output | 1 | Modulated output bit |
| bitVld | output | 1 | Pulses for one cycle when a new `bitOut` is available |

## Verification
A wrong integrator value normally reaches the ports within a few accepted samples, because each integrator feeds every stage above it and the quantizer. The quantizer then places a bit of the wrong polarity, one cycle after the sample that caused it. For that reason the bench compares every bit against its own cycle-exact model of the loop. Separate instances give first-order weight sets, where the loop is stable, and a feedback-free set with large input weights, where clamping is reached within two samples. An error in the clamp or in the zeroing of the upper stages shows up there as a stuck or inverted bit.

// File: rtl/nshape_pkg.sv
package nshape_pkg;
  localparam int MAX_ORD = 5;   // stages present in hardware
  localparam int LOW_ORD = 3;   // stages used in the reduced mode
  localparam int COEF_W  = 16;  // width of one stage weight

  typedef logic signed [COEF_W-1:0] coef_t;
  typedef coef_t [MAX_ORD-1:0] coefSet_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clrState;
    logic step;
    logic useFifth;
  } ctrlStrobe_t;
endpackage

// File: rtl/nshape_ctrl.sv
module nshape_ctrl (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleVld,
  input  logic                     fifthOrder,
  output nshape_pkg::ctrlStrobe_t  strobe,
  output logic                     bitVld
);
  always_comb begin
    strobe.clrState = rst;
    strobe.step     = sampleVld && !rst;
    strobe.useFifth = fifthOrder;
  end

  // one output bit per accepted sample, one cycle later
  always_ff @(posedge clk) begin
    bitVld <= strobe.step;
  end
endmodule

// File: rtl/nshape_stage.sv
module nshape_stage #(
  parameter int ACC_W  = 40,
  parameter int WIDE_W = 44
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     step,
  input  logic                     active,
  input  logic signed [WIDE_W-1:0] sumIn,
  output logic signed [ACC_W-1:0]  stateNext,
  output logic signed [ACC_W-1:0]  stateQ
);
  localparam logic signed [ACC_W-1:0]  SAT_HI  = {1'b0, {(ACC_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0]  SAT_LO  = {1'b1, {(ACC_W-1){1'b0}}};
  localparam logic signed [WIDE_W-1:0] WIDE_HI = WIDE_W'(SAT_HI);
  localparam logic signed [WIDE_W-1:0] WIDE_LO = WIDE_W'(SAT_LO);

  logic signed [ACC_W-1:0] clampVal;

  always_comb begin
    if (sumIn > WIDE_HI)      clampVal = SAT_HI;
    else if (sumIn < WIDE_LO) clampVal = SAT_LO;
    else                      clampVal = sumIn[ACC_W-1:0];
  end

  assign stateNext = active ? clampVal : '0;

  always_ff @(posedge clk) begin
    if (clr)       stateQ <= '0;
    else if (step) stateQ <= stateNext;
  end
endmodule

// File: rtl/nshape_dpath.sv
module nshape_dpath #(
  parameter int                   DATA_W = 24,
  parameter int                   ACC_W  = 40,
  parameter nshape_pkg::coefSet_t A_COEF = '0,
  parameter nshape_pkg::coefSet_t B_COEF = '0
) (
  input  logic                                            clk,
  input  nshape_pkg::ctrlStrobe_t                         strobe,
  input  logic signed [DATA_W-1:0]                        sampleIn,
  output logic                                            bitOut,
  output logic [nshape_pkg::MAX_ORD-1:0][ACC_W-1:0]       stateOut
);
  import nshape_pkg::*;

  localparam int WIDE_W = ACC_W + 4;
  localparam logic signed [WIDE_W-1:0] FS_W = WIDE_W'(1) << (DATA_W - 1);

  logic signed [WIDE_W-1:0] xWide;
  logic signed [WIDE_W-1:0] fbWide;
  logic signed [WIDE_W-1:0] termS   [MAX_ORD];
  logic signed [WIDE_W-1:0] stWide  [MAX_ORD];
  logic signed [WIDE_W-1:0] sumW    [MAX_ORD];
  logic signed [ACC_W-1:0]  stQ     [MAX_ORD];
  logic signed [ACC_W-1:0]  stNx    [MAX_ORD];
  logic                     stageOn [MAX_ORD];
  logic                     bitQ;
  logic signed [ACC_W-1:0]  selNext;

  assign xWide  = WIDE_W'(sampleIn);
  assign fbWide = bitQ ? FS_W : -FS_W;

  for (genvar k = 0; k < MAX_ORD; k++) begin : g_stage
    logic signed [WIDE_W-1:0] aW;
    logic signed [WIDE_W-1:0] bW;
    assign aW       = WIDE_W'($signed(A_COEF[k]));
    assign bW       = WIDE_W'($signed(B_COEF[k]));
    assign termS[k] = bW * xWide - aW * fbWide;
    assign stWide[k] = WIDE_W'(stQ[k]);
    assign stageOn[k] = (k < LOW_ORD) || strobe.useFifth;

    if (k == 0) begin : g_first
      assign sumW[k] = stWide[k] + termS[k];
    end else if (k % 2 == 1) begin : g_even
      assign sumW[k] = stWide[k] + termS[k] + stWide[k-1];
    end else begin : g_odd
      assign sumW[k] = stWide[k] + termS[k] + stWide[k-1] + termS[k-1] + stWide[k-2];
    end

    nshape_stage #(.ACC_W(ACC_W), .WIDE_W(WIDE_W)) u_stage (
      .clk      (clk),
      .clr      (strobe.clrState),
      .step     (strobe.step),
      .active   (stageOn[k]),
      .sumIn    (sumW[k]),
      .stateNext(stNx[k]),
      .stateQ   (stQ[k])
    );

    assign stateOut[k] = stQ[k];
  end

  assign selNext = strobe.useFifth ? stNx[MAX_ORD-1] : stNx[LOW_ORD-1];

  always_ff @(posedge clk) begin
    if (strobe.clrState)  bitQ <= 1'b0;
    else if (strobe.step) bitQ <= !selNext[ACC_W-1];
  end

  assign bitOut = bitQ;
endmodule

// File: rtl/nshape_mod.sv
module nshape_mod #(
  parameter int                   DATA_W = 24,
  parameter int                   ACC_W  = 40,
  parameter nshape_pkg::coefSet_t A_COEF = {16'sd1, 16'sd1, 16'sd2, 16'sd2, 16'sd3},
  parameter nshape_pkg::coefSet_t B_COEF = {16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd3}
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     sampleVld,
  input  logic signed [DATA_W-1:0] sampleIn,
  input  logic                     fifthOrder,
  output logic                     bitOut,
  output logic                     bitVld
);
  nshape_pkg::ctrlStrobe_t strobe;
  logic [nshape_pkg::MAX_ORD-1:0][ACC_W-1:0] stageState;

  nshape_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .sampleVld (sampleVld),
    .fifthOrder(fifthOrder),
    .strobe    (strobe),
    .bitVld    (bitVld)
  );

  nshape_dpath #(
    .DATA_W(DATA_W), .ACC_W(ACC_W), .A_COEF(A_COEF), .B_COEF(B_COEF)
  ) u_dpath (
    .clk     (clk),
    .strobe  (strobe),
    .sampleIn(sampleIn),
    .bitOut  (bitOut),
    .stateOut(stageState)
  );
endmodule

// File: rtl/nshape_chk.sv
module nshape_chk #(
  parameter int ACC_W   = 40,
  parameter int MAX_ORD = 5,
  parameter int LOW_ORD = 3
) (
  input logic                            clk,
  input logic                            rst,
  input logic                            sampleVld,
  input logic                            fifthOrder,
  input logic                            bitOut,
  input logic                            bitVld,
  input logic [MAX_ORD-1:0][ACC_W-1:0]   stageState
);
  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (!bitOut && !bitVld && stageState == '0));

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    sampleVld |=> bitVld);

  assert_no_extra_valid_R2: assert property (@(posedge clk) disable iff (rst)
    !sampleVld |=> !bitVld);

  assert_bit_sign_R3: assert property (@(posedge clk) disable iff (rst)
    bitVld |-> (bitOut == ($past(fifthOrder) ? !stageState[MAX_ORD-1][ACC_W-1]
                                             : !stageState[LOW_ORD-1][ACC_W-1])));

  assert_upper_parked_R6: assert property (@(posedge clk) disable iff (rst)
    (sampleVld && !fifthOrder) |=> (stageState[MAX_ORD-1:LOW_ORD] == '0));

  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !sampleVld |=> ($stable(bitOut) && $stable(stageState)));
endmodule

bind nshape_mod nshape_chk #(
  .ACC_W(ACC_W), .MAX_ORD(nshape_pkg::MAX_ORD), .LOW_ORD(nshape_pkg::LOW_ORD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sampleVld (sampleVld),
  .fifthOrder(fifthOrder),
  .bitOut    (bitOut),
  .bitVld    (bitVld),
  .stageState(stageState)
);

// File: tb/nshape_mod_tb_top.sv
module nshape_mod_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int     DW = 24;
  localparam longint FS = 64'sd1 << (DW - 1);
  localparam longint LIM_HI = (64'sd1 <<< 39) - 1;
  localparam longint LIM_LO = -(64'sd1 <<< 39);

  localparam nshape_pkg::coefSet_t MAIN_A = {16'sd1, 16'sd1, 16'sd2, 16'sd2, 16'sd3};
  localparam nshape_pkg::coefSet_t MAIN_B = {16'sd1, 16'sd1, 16'sd1, 16'sd1, 16'sd3};
  localparam nshape_pkg::coefSet_t SAT_A  = '0;
  localparam nshape_pkg::coefSet_t SAT_B  = {5{16'sd32767}};
  localparam nshape_pkg::coefSet_t DC3_W  = {16'sd0, 16'sd0, 16'sd1, 16'sd0, 16'sd0};
  localparam nshape_pkg::coefSet_t DC5_W  = {16'sd1, 16'sd0, 16'sd0, 16'sd0, 16'sd0};

  // segment: [40] five-stage mode, [39:24] sample count, [23:0] input
  localparam int NSEG = 8;
  localparam logic [40:0] SEG [NSEG] = '{
    {1'b0, 16'd24,  24'h000000},
    {1'b0, 16'd40,  24'h200000},
    {1'b1, 16'd60,  24'hD55556},
    {1'b1, 16'd30,  24'h0003E8},
    {1'b0, 16'd30,  24'h800001},
    {1'b1, 16'd40,  24'h7FFFFF},
    {1'b1, 16'd200, 24'h7FFFFF},
    {1'b0, 16'd50,  24'h9C4000}
  };

  logic clk = 1'b0;
  logic rst;
  logic sampleVld;
  logic signed [DW-1:0] sampleIn;
  logic fifthOrder;
  logic [3:0] bo;
  logic [3:0] bv;

  int nChk = 0;
  int nFail = 0;

  longint cA [4][5];
  longint cB [4][5];
  longint mSt [4][5];
  bit     mBit [4];

  always #2.5 clk = ~clk;

  nshape_mod #(.DATA_W(DW), .ACC_W(40), .A_COEF(MAIN_A), .B_COEF(MAIN_B)) dut_i (
    .clk(clk), .rst(rst), .sampleVld(sampleVld), .sampleIn(sampleIn),
    .fifthOrder(fifthOrder), .bitOut(bo[0]), .bitVld(bv[0]));
  nshape_mod #(.DATA_W(DW), .ACC_W(40), .A_COEF(SAT_A), .B_COEF(SAT_B)) dut_sat_i (
    .clk(clk), .rst(rst), .sampleVld(sampleVld), .sampleIn(sampleIn),
    .fifthOrder(fifthOrder), .bitOut(bo[1]), .bitVld(bv[1]));
  nshape_mod #(.DATA_W(DW), .ACC_W(40), .A_COEF(DC3_W), .B_COEF(DC3_W)) dut_dc3_i (
    .clk(clk), .rst(rst), .sampleVld(sampleVld), .sampleIn(sampleIn),
    .fifthOrder(1'b0), .bitOut(bo[2]), .bitVld(bv[2]));
  nshape_mod #(.DATA_W(DW), .ACC_W(40), .A_COEF(DC5_W), .B_COEF(DC5_W)) dut_dc5_i (
    .clk(clk), .rst(rst), .sampleVld(sampleVld), .sampleIn(sampleIn),
    .fifthOrder(1'b1), .bitOut(bo[3]), .bitVld(bv[3]));

  function automatic longint clampAcc(longint v);
    if (v > LIM_HI) return LIM_HI;
    if (v < LIM_LO) return LIM_LO;
    return v;
  endfunction

  function automatic bit instMode(int i, bit f);
    if (i == 2) return 1'b0;
    if (i == 3) return 1'b1;
    return f;
  endfunction

  function automatic string instTag(int i, bit f, string ovr);
    if (i == 0 && ovr != "") return ovr;
    if (i == 0) return f ? "R5" : "R6";
    if (i == 1) return "R8";
    return "R3";
  endfunction

  task automatic modelReset();
    for (int i = 0; i < 4; i++) begin
      mBit[i] = 1'b0;
      for (int k = 0; k < 5; k++) mSt[i][k] = 0;
    end
  endtask

  // one loop update per requirements R3..R8
  task automatic modelStep(int i, longint x, bit f);
    longint fb;
    longint t [5];
    longint n [5];
    fb = mBit[i] ? FS : -FS;
    for (int k = 0; k < 5; k++) t[k] = cB[i][k] * x - cA[i][k] * fb;
    n[0] = clampAcc(mSt[i][0] + t[0]);
    n[1] = clampAcc(mSt[i][1] + t[1] + mSt[i][0]);
    n[2] = clampAcc(mSt[i][2] + t[2] + t[1] + mSt[i][1] + mSt[i][0]);
    n[3] = f ? clampAcc(mSt[i][3] + t[3] + mSt[i][2]) : 0;
    n[4] = f ? clampAcc(mSt[i][4] + t[4] + t[3] + mSt[i][3] + mSt[i][2]) : 0;
    mBit[i] = f ? (n[4] >= 0) : (n[2] >= 0);
    for (int k = 0; k < 5; k++) mSt[i][k] = n[k];
  endtask

  task automatic checkEq(string req, string what, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge after checking
  task automatic doStep(logic signed [DW-1:0] x, bit f, bit vld, string ovr);
    sampleIn   = x;
    fifthOrder = f;
    sampleVld  = vld;
    if (vld) for (int i = 0; i < 4; i++) modelStep(i, longint'(x), instMode(i, f));
    @(posedge clk);
    @(negedge clk);
    sampleVld = 1'b0;
    for (int i = 0; i < 4; i++) begin
      checkEq("R2", $sformatf("valid inst%0d", i), longint'(bv[i]), longint'(vld));
      checkEq(vld ? instTag(i, instMode(i, f), ovr) : "R9",
              $sformatf("bit inst%0d", i), longint'(bo[i]), longint'(mBit[i]));
    end
  endtask

  task automatic dcRun(logic signed [DW-1:0] x, int expOnes);
    int ones3;
    int ones5;
    ones3 = 0;
    ones5 = 0;
    for (int j = 0; j < 1024; j++) begin
      doStep(x, 1'b1, 1'b1, "");
      ones3 += int'(bo[2]);
      ones5 += int'(bo[3]);
    end
    nChk++;
    if (ones3 < expOnes - 3 || ones3 > expOnes + 3) begin
      nFail++;
      $display("FAIL R10 three-stage ones: actual %0d expected %0d", ones3, expOnes);
    end
    nChk++;
    if (ones5 < expOnes - 3 || ones5 > expOnes + 3) begin
      nFail++;
      $display("FAIL R10 five-stage ones: actual %0d expected %0d", ones5, expOnes);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk + 1, nFail);
    $finish;
  end

  initial begin
    bit prevF;
    bit f;
    int n;
    logic signed [DW-1:0] x;

    for (int k = 0; k < 5; k++) begin
      cA[0][k] = longint'($signed(MAIN_A[k]));
      cB[0][k] = longint'($signed(MAIN_B[k]));
      cA[1][k] = longint'($signed(SAT_A[k]));
      cB[1][k] = longint'($signed(SAT_B[k]));
      cA[2][k] = longint'($signed(DC3_W[k]));
      cB[2][k] = longint'($signed(DC3_W[k]));
      cA[3][k] = longint'($signed(DC5_W[k]));
      cB[3][k] = longint'($signed(DC5_W[k]));
    end

    rst = 1'b1;
    sampleVld = 1'b0;
    sampleIn = '0;
    fifthOrder = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    // R1: state after reset
    for (int i = 0; i < 4; i++) begin
      checkEq("R1", $sformatf("bitOut inst%0d", i), longint'(bo[i]), 0);
      checkEq("R1", $sformatf("bitVld inst%0d", i), longint'(bv[i]), 0);
    end

    // R4: first feedback is -FS, so zero input gives a 1
    doStep('0, 1'b0, 1'b1, "R4");
    checkEq("R4", "first bit main", longint'(bo[0]), 1);
    checkEq("R4", "first bit dc3", longint'(bo[2]), 1);

    // table walk: R5, R6, R7, R8, R9
    prevF = 1'b0;
    for (int s = 0; s < NSEG; s++) begin
      f = SEG[s][40];
      n = int'(SEG[s][39:24]);
      x = SEG[s][23:0];
      for (int j = 0; j < n; j++) begin
        doStep(x, f, 1'b1, (j == 0 && f && !prevF) ? "R7" : "");
        if (j % 5 == 4) doStep(x, f, 1'b0, "");
      end
      prevF = f;
    end

    // R11: reset in mid-stream
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    modelReset();
    for (int i = 0; i < 4; i++) begin
      checkEq("R11", $sformatf("bitOut inst%0d", i), longint'(bo[i]), 0);
      checkEq("R11", $sformatf("bitVld inst%0d", i), longint'(bv[i]), 0);
    end
    doStep('0, 1'b0, 1'b1, "R11");
    checkEq("R11", "first bit after reset", longint'(bo[0]), 1);

    // R10: DC tracking at +FS/2 and -FS/4
    dcRun(24'sh400000, 768);
    dcRun(-24'sh200000, 384);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule